// File: doc/BRIEF.md
# Load Clock Divider with Even Duty at Odd Ratios

This block derives a slower load clock from a fast pixel clock. A small code picks the division ratio from the fixed set 3, 4, 5, 6, 8 and 10, and the code can change at any time, for example whenever a new frequency entry is selected. The load clock keeps an equal high and low time for every ratio. For the odd ratios this comes from a half-cycle extension timed on the falling clock edge.

An enable input can hold the load clock low for entries that do not use it. The divider samples the ratio code and the enable only at the end of each output period. A change therefore never shortens or stretches a pulse that is already under way. A synchronous reset clears the divider, and the next output period starts on the first clock edge after reset is released.

Top module: `load_clk_divider`

## Requirements
- R1: The output period is N clocks. N is 3, 4, 5, 6, 8 or 10 for `mod_sel` codes 0, 1, 2, 3, 4 and 5 in that order.
- R2: For the even ratios (4, 6, 8, 10), the output is high for exactly N/2 clocks of each period. The high time begins on a rising clock edge.
- R3: For the odd ratios (3, 5), the output is high for N/2 clocks, which is (N-1)/2 whole clocks plus one half clock. The rising edge comes on a rising clock edge and the falling edge comes on a falling clock edge.
- R4: `mod_sel` codes 6 and 7 divide by 4, with the same timing as code 1.
- R5: While the sampled enable is low, the output stays low. When `out_en` is lowered in the middle of a period, that period still completes its full high time, and the output then stays low.
- R6: The divider samples `mod_sel` only at a period boundary. When the code changes in the middle of a period, the running period completes at the old length and high time. The next period uses the new ratio.
- R7: While `rst` is held high, the output is low from the second clock edge on. After `rst` is released, the first rising clock edge starts a full, correct period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast pixel clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| mod_sel | input | 3 | Division ratio code |
| out_en | input | 1 | Load clock enable; low forces the output low |
| load_clk | output | 1 | Divided load clock |

## Verification
If the position counter is wrong, the distance between two load clock rising edges is wrong. This shows up within one output period, at most ten clocks. If the falling-edge copy stays off or runs too long, the high time of odd ratios is off by half a clock in the very first period. The bench samples twice per clock, so it sees this error. If the boundary logic latches the ratio or the enable early, a period made of two ratios appears right after the mid-period change. If it latches too late, the old ratio runs on for an extra period. Both errors show up within two periods.

// File: rtl/load_clk_divider.sv
module load_clk_divider (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mod_sel,
  input  logic       out_en,
  output logic       load_clk
);

  function automatic logic [3:0] ratio_of(input logic [2:0] code);
    case (code)
      3'd0:    ratio_of = 4'd3;
      3'd1:    ratio_of = 4'd4;
      3'd2:    ratio_of = 4'd5;
      3'd3:    ratio_of = 4'd6;
      3'd4:    ratio_of = 4'd8;
      3'd5:    ratio_of = 4'd10;
      default: ratio_of = 4'd4;
    endcase
  endfunction

  logic [2:0] code_q;
  logic       en_q;
  logic       fresh_q;
  logic [3:0] cnt_q;
  logic       hi_q;
  logic       neg_q;

  logic [3:0] n_cur;
  logic [3:0] n_nx;
  logic [3:0] cnt_nx;
  logic       en_nx;
  logic       boundary;

  assign n_cur    = ratio_of(code_q);
  assign boundary = fresh_q || (cnt_q == n_cur - 4'd1);
  assign n_nx     = boundary ? ratio_of(mod_sel) : n_cur;
  assign cnt_nx   = boundary ? 4'd0 : cnt_q + 4'd1;
  assign en_nx    = boundary ? out_en : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= 3'd0;
      en_q    <= 1'b0;
      fresh_q <= 1'b1;
      cnt_q   <= 4'd0;
      hi_q    <= 1'b0;
    end else begin
      if (boundary) code_q <= mod_sel;
      en_q    <= en_nx;
      fresh_q <= 1'b0;
      cnt_q   <= cnt_nx;
      hi_q    <= en_nx && (cnt_nx < (n_nx >> 1));
    end
  end

  always_ff @(negedge clk) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= hi_q & n_cur[0];
  end

  assign load_clk = hi_q | neg_q;

  // R7
  rst_clears_chk: assert property (@(posedge clk) rst |=> (cnt_q == 4'd0 && !hi_q));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt_q < n_cur);

  // R6
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(code_q) && $stable(en_q)));

  // R2
  start_high_chk: assert property (@(posedge clk) disable iff (rst)
    (boundary && out_en) |=> load_clk);

  // R5
  off_low_chk: assert property (@(posedge clk) disable iff (rst) !en_q |-> !hi_q);

  // R3
  neg_follows_chk: assert property (@(posedge clk) disable iff (rst) neg_q |-> hi_q);

endmodule

// File: tb/load_clk_divider_tb.sv
module load_clk_divider_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] mod_sel = 3'd0;
  logic out_en = 1'b1;
  logic load_clk;

  int errors = 0;
  int checks = 0;
  logic cur = 1'b0;
  logic prev = 1'b0;
  bit done = 1'b0;

  load_clk_divider u_dut (
    .clk(clk), .rst(rst), .mod_sel(mod_sel), .out_en(out_en), .load_clk(load_clk)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic sample_half();
    @(clk);
    #2;
    prev = cur;
    cur  = load_clk;
  endtask

  task automatic sync_rise(input string req);
    int k;
    for (k = 0; k < 200; k++) begin
      sample_half();
      if (!prev && cur) break;
    end
    if (k == 200) check(1'b0, req, 0, 1);
  endtask

  task automatic measure(input int chg_at, input logic [2:0] chg_val,
                         output int len, output int hi);
    len = 0;
    hi  = 0;
    for (int k = 0; k < 200; k++) begin
      len++;
      if (cur) hi++;
      if (len == chg_at) mod_sel = chg_val;
      sample_half();
      if (!prev && cur) break;
    end
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(load_clk == 1'b0, "R7 low in reset", load_clk, 0);
    rst = 1'b0;
  endtask

  task automatic test_ratio(input logic [2:0] code, input int n, input string req);
    int len, hi;
    mod_sel = code;
    sync_rise(req);
    measure(0, 3'd0, len, hi);
    for (int p = 0; p < 2; p++) begin
      measure(0, 3'd0, len, hi);
      check(len == 2 * n, {req, " R1 period halves"}, len, 2 * n);
      check(hi == n, {req, " high halves"}, hi, n);
    end
  endtask

  task automatic test_midchange();
    int len, hi;
    mod_sel = 3'd5;
    sync_rise("R6");
    measure(0, 3'd0, len, hi);
    measure(6, 3'd0, len, hi);
    check(len == 20, "R6 old period length kept", len, 20);
    check(hi == 10, "R6 old high time kept", hi, 10);
    measure(0, 3'd0, len, hi);
    check(len == 6, "R6 new period length", len, 6);
    check(hi == 3, "R6 new high time", hi, 3);
  endtask

  task automatic test_disable();
    int hi, len;
    mod_sel = 3'd5;
    sync_rise("R5");
    measure(0, 3'd0, len, hi);
    for (int k = 0; k < 5; k++) sample_half();
    out_en = 1'b0;
    hi = 0;
    for (int k = 0; k < 14; k++) begin
      sample_half();
      if (cur) hi++;
    end
    check(hi == 4, "R5 running pulse completes", hi, 4);
    hi = 0;
    for (int k = 0; k < 40; k++) begin
      sample_half();
      if (cur) hi++;
    end
    check(hi == 0, "R5 held low while disabled", hi, 0);
    out_en = 1'b1;
    sync_rise("R5");
    measure(0, 3'd0, len, hi);
    check(len == 20 && hi == 10, "R5 resumes after enable", len * 100 + hi, 2010);
  endtask

  task automatic test_reset_midrun();
    int len, hi, seen;
    mod_sel = 3'd4;
    sync_rise("R7");
    sample_half();
    sample_half();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #2;
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      if (load_clk) seen++;
      sample_half();
    end
    check(seen == 0, "R7 low during mid-run reset", seen, 0);
    rst = 1'b0;
    sync_rise("R7");
    measure(0, 3'd0, len, hi);
    check(len == 16, "R7 first period after reset", len, 16);
    check(hi == 8, "R7 first high after reset", hi, 8);
  endtask

  initial begin
    #1600000;
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    test_reset();
    test_ratio(3'd0, 3, "R3 div3");
    test_ratio(3'd1, 4, "R2 div4");
    test_ratio(3'd2, 5, "R3 div5");
    test_ratio(3'd3, 6, "R2 div6");
    test_ratio(3'd4, 8, "R2 div8");
    test_ratio(3'd5, 10, "R2 div10");
    test_ratio(3'd6, 4, "R4 code6");
    test_ratio(3'd7, 4, "R4 code7");
    test_midchange();
    test_disable();
    test_reset_midrun();
    summary();
  end
endmodule